// File: doc/BRIEF.md
# Paged Transfer CRC-16 Sequencer

This block produces the check word that a memory slave returns to the bus master during read and write transfers. Bytes arrive one at a time, each with a tag that marks it as a command, an address low byte, an address high byte or a data byte. From these bytes the sequencer decides when to clear its 16-bit CRC register, when to fold a byte in, when to load the register with the running address, and when to present the complemented result for transmission. Byte serialisation, the memory array and the bus physical layer sit outside the block.

A transfer begins with a one-cycle `txn_start` pulse. The sequencer samples the transfer direction from `txn_write` on that pulse. In read mode it returns a check word at every page boundary, and each later page starts from a cleared register. In write mode it returns a check word after every data byte, and from the second data byte on, the register first takes the incremented address rather than having it shifted in.

The FSM has seven states. `ST_IDLE` holds after reset. `ST_CMD`, `ST_ALO` and `ST_AHI` wait for the header bytes in that order. `ST_DATA` takes data bytes. `ST_EMIT_LO` and `ST_EMIT_HI` present the check word. The transitions are: start (any state to `ST_CMD`), header advance (`ST_CMD` to `ST_ALO` to `ST_AHI` to `ST_DATA`), page or byte end (`ST_DATA` to `ST_EMIT_LO`), data continue (`ST_DATA` to `ST_DATA`), high half (`ST_EMIT_LO` to `ST_EMIT_HI`) and next pass (`ST_EMIT_HI` to `ST_DATA`). The next-pass transition clears the register in read mode and loads it with the address in write mode.

Top module: `xfer_crc_seq`

## Requirements
- R1: Each accepted byte updates the CRC least significant bit first with the reflected polynomial x^16+x^15+x^2+1 (mask 0xA001), and a cleared register is 0x0000. A read header of 0x31,0x32,0x33 followed by data 0x34..0x39 therefore yields the check word 0x44C2.
- R2: `crc_out` is always the bitwise complement of the internal CRC register, so it reads 0xFFFF while the register is clear.
- R3: After reset the sequencer is idle. `crc_ready` and `crc_byte_valid` are low, and bytes of any tag have no effect until `txn_start` is seen.
- R4: Tag encoding is 0 for command, 1 for address low, 2 for address high and 3 for data. Header bytes are accepted only in the order command, address low, address high. A byte whose tag does not match the expected slot is ignored.
- R5: On the first read pass the CRC is cleared at `txn_start`. The command, both address bytes and the data bytes are then folded in until the byte at an address whose low three bits are 7, after which the check word is emitted. A read that starts mid-page therefore ends early.
- R6: On each later read pass the CRC restarts from zero and covers only that page's data bytes, with the same page-end rule.
- R7: On the first write pass the CRC covers the command, address low, address high and exactly one data byte, and is then emitted.
- R8: On each later write pass the register is loaded with the incremented 16-bit address (it is not shifted in), then the next data byte is folded in and the result is emitted.
- R9: `crc_ready` is high for exactly one cycle, and in that cycle `crc_byte` carries the low byte of the inverted word. In the following cycle `crc_byte` carries the high byte, `crc_out` is unchanged, and `crc_byte_valid` covers both cycles. Bytes offered during these two cycles are ignored.
- R10: `txn_start` takes priority over any byte in the same cycle. It returns the sequencer from any state to waiting for a command, clears the CRC and the address, and samples `txn_write` (1 = write).
- R11: The address counter is 16 bits wide and wraps from 0xFFFF to 0x0000. A wrapped address is loaded and counted for page ends like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | One-cycle pulse that begins a transfer |
| txn_write | input | 1 | Transfer direction sampled at start, 1 = write |
| byte_valid | input | 1 | Byte on `byte_data` is offered this cycle |
| byte_tag | input | 2 | Byte role: 0 command, 1 addr low, 2 addr high, 3 data |
| byte_data | input | 8 | Byte value |
| crc_ready | output | 1 | One-cycle strobe, check word available |
| crc_out | output | 16 | Complemented CRC register |
| crc_byte | output | 8 | Check word byte being presented, low then high |
| crc_byte_valid | output | 1 | `crc_byte` is meaningful (two cycles per word) |

## Verification
On every cycle the assertions check the shape of the emit window: the strobe lasts a single cycle, the low byte comes with the strobe, the high byte follows with the word held steady, a strobe only ever follows an offered byte, and a start pulse always leaves the emit outputs idle. Only the bench scenarios can show whether the CRC values are right. They cover the header and pass sequencing, clearing versus address loading between passes, mid-page starts, address wrap, and the fact that misplaced, pre-start and mid-emit bytes change nothing.

// File: rtl/xfer_crc_pkg.sv
package xfer_crc_pkg;

    localparam int CRC_W  = 16;
    localparam int ADDR_W = 16;
    localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;

    typedef enum logic [1:0] {
        TAG_CMD  = 2'd0,
        TAG_ALO  = 2'd1,
        TAG_AHI  = 2'd2,
        TAG_DATA = 2'd3
    } tag_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SHIFT = 2'd2,
        OP_LOAD  = 2'd3
    } crc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CMD     = 3'd1,
        ST_ALO     = 3'd2,
        ST_AHI     = 3'd3,
        ST_DATA    = 3'd4,
        ST_EMIT_LO = 3'd5,
        ST_EMIT_HI = 3'd6
    } seq_state_e;

    // Fold one byte into the register, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] cur,
                                                  input logic [7:0] din);
        logic [CRC_W-1:0] r;
        r = cur;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ din[i]) r = (r >> 1) ^ POLY_REFL;
            else               r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/xfer_crc_reg.sv
module xfer_crc_reg
    import xfer_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  crc_op_e          op,
    input  logic [7:0]       din,
    input  logic [CRC_W-1:0] load_val,
    output logic [CRC_W-1:0] crc_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else begin
            unique case (op)
                OP_HOLD:  crc_q <= crc_q;
                OP_CLEAR: crc_q <= '0;
                OP_SHIFT: crc_q <= crc_fold(crc_q, din);
                OP_LOAD:  crc_q <= load_val;
                default:  crc_q <= crc_q;
            endcase
        end
    end

endmodule

// File: rtl/xfer_addr_ctr.sv
module xfer_addr_ctr
    import xfer_crc_pkg::*;
#(
    parameter int PAGE_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              inc,
    input  logic [7:0]        din,
    output logic [ADDR_W-1:0] addr_q,
    output logic              page_last
);

    localparam int PAGE_BITS = $clog2(PAGE_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clr) begin
            addr_q <= '0;
        end else if (ld_lo) begin
            addr_q[7:0] <= din;
        end else if (ld_hi) begin
            addr_q[ADDR_W-1:8] <= din[ADDR_W-9:0];
        end else if (inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    generate
        if (PAGE_BITS == 0) begin : g_single
            assign page_last = 1'b1;
        end else begin : g_paged
            assign page_last = &addr_q[PAGE_BITS-1:0];
        end
    endgenerate

endmodule

// File: rtl/xfer_crc_fsm.sv
module xfer_crc_fsm
    import xfer_crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start,
    input  logic       txn_write,
    input  logic       byte_valid,
    input  logic [1:0] byte_tag,
    input  logic       page_last,
    output crc_op_e    crc_op,
    output logic       addr_clr,
    output logic       addr_ld_lo,
    output logic       addr_ld_hi,
    output logic       addr_inc,
    output logic       crc_ready,
    output logic       crc_byte_valid,
    output logic       sel_hi
);

    seq_state_e state, nxt;
    logic       mode_wr;
    logic       take_cmd, take_alo, take_ahi, take_data;

    assign take_cmd  = byte_valid && (byte_tag == TAG_CMD);
    assign take_alo  = byte_valid && (byte_tag == TAG_ALO);
    assign take_ahi  = byte_valid && (byte_tag == TAG_AHI);
    assign take_data = byte_valid && (byte_tag == TAG_DATA);

    // State register (and direction sampled at start)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_wr <= 1'b0;
        end else begin
            state <= nxt;
            if (txn_start) mode_wr <= txn_write;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        if (txn_start) begin
            nxt = ST_CMD;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_CMD:     if (take_cmd) nxt = ST_ALO;
                ST_ALO:     if (take_alo) nxt = ST_AHI;
                ST_AHI:     if (take_ahi) nxt = ST_DATA;
                ST_DATA:    if (take_data)
                                nxt = (mode_wr || page_last) ? ST_EMIT_LO : ST_DATA;
                ST_EMIT_LO: nxt = ST_EMIT_HI;
                ST_EMIT_HI: nxt = ST_DATA;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        crc_op         = OP_HOLD;
        addr_clr       = 1'b0;
        addr_ld_lo     = 1'b0;
        addr_ld_hi     = 1'b0;
        addr_inc       = 1'b0;
        crc_ready      = 1'b0;
        crc_byte_valid = 1'b0;
        sel_hi         = 1'b0;
        if (txn_start) begin
            crc_op   = OP_CLEAR;
            addr_clr = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_CMD: if (take_cmd) crc_op = OP_SHIFT;
                ST_ALO: if (take_alo) begin
                    crc_op     = OP_SHIFT;
                    addr_ld_lo = 1'b1;
                end
                ST_AHI: if (take_ahi) begin
                    crc_op     = OP_SHIFT;
                    addr_ld_hi = 1'b1;
                end
                ST_DATA: if (take_data) begin
                    crc_op   = OP_SHIFT;
                    addr_inc = 1'b1;
                end
                ST_EMIT_LO: begin
                    crc_ready      = 1'b1;
                    crc_byte_valid = 1'b1;
                end
                ST_EMIT_HI: begin
                    crc_byte_valid = 1'b1;
                    sel_hi         = 1'b1;
                    crc_op         = mode_wr ? OP_LOAD : OP_CLEAR;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xfer_crc_seq.sv
module xfer_crc_seq
    import xfer_crc_pkg::*;
#(
    parameter int PAGE_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        txn_start,
    input  logic        txn_write,
    input  logic        byte_valid,
    input  logic [1:0]  byte_tag,
    input  logic [7:0]  byte_data,
    output logic        crc_ready,
    output logic [15:0] crc_out,
    output logic [7:0]  crc_byte,
    output logic        crc_byte_valid
);

    crc_op_e           crc_op;
    logic              addr_clr, addr_ld_lo, addr_ld_hi, addr_inc;
    logic              page_last, sel_hi;
    logic [ADDR_W-1:0] addr_q;
    logic [CRC_W-1:0]  crc_q;

    xfer_crc_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .txn_start      (txn_start),
        .txn_write      (txn_write),
        .byte_valid     (byte_valid),
        .byte_tag       (byte_tag),
        .page_last      (page_last),
        .crc_op         (crc_op),
        .addr_clr       (addr_clr),
        .addr_ld_lo     (addr_ld_lo),
        .addr_ld_hi     (addr_ld_hi),
        .addr_inc       (addr_inc),
        .crc_ready      (crc_ready),
        .crc_byte_valid (crc_byte_valid),
        .sel_hi         (sel_hi)
    );

    xfer_addr_ctr #(.PAGE_BYTES(PAGE_BYTES)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (addr_clr),
        .ld_lo     (addr_ld_lo),
        .ld_hi     (addr_ld_hi),
        .inc       (addr_inc),
        .din       (byte_data),
        .addr_q    (addr_q),
        .page_last (page_last)
    );

    xfer_crc_reg u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (crc_op),
        .din      (byte_data),
        .load_val (CRC_W'(addr_q)),
        .crc_q    (crc_q)
    );

    assign crc_out  = ~crc_q;
    assign crc_byte = sel_hi ? crc_out[15:8] : crc_out[7:0];

endmodule

// File: rtl/xfer_crc_seq_chk.sv
module xfer_crc_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        txn_start,
    input logic        byte_valid,
    input logic        crc_ready,
    input logic [15:0] crc_out,
    input logic [7:0]  crc_byte,
    input logic        crc_byte_valid
);

    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ready |=> !crc_ready);

    a_r9_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ready |-> (crc_byte_valid && crc_byte == crc_out[7:0]));

    a_r9_high_next: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ready && !txn_start) |=> (crc_byte_valid && crc_byte == $past(crc_out[15:8])));

    a_r9_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ready && !txn_start) |=> $stable(crc_out));

    a_r10_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> !crc_byte_valid);

    a_r7_strobe_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_ready) |-> $past(byte_valid));

endmodule

bind xfer_crc_seq xfer_crc_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .txn_start      (txn_start),
    .byte_valid     (byte_valid),
    .crc_ready      (crc_ready),
    .crc_out        (crc_out),
    .crc_byte       (crc_byte),
    .crc_byte_valid (crc_byte_valid)
);

// File: tb/xfer_crc_seq_bench.sv
module xfer_crc_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        txn_start, txn_write, byte_valid;
    logic [1:0]  byte_tag;
    logic [7:0]  byte_data;
    logic        crc_ready, crc_byte_valid;
    logic [15:0] crc_out;
    logic [7:0]  crc_byte;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xfer_crc_seq u_xfer_crc_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .txn_start      (txn_start),
        .txn_write      (txn_write),
        .byte_valid     (byte_valid),
        .byte_tag       (byte_tag),
        .byte_data      (byte_data),
        .crc_ready      (crc_ready),
        .crc_out        (crc_out),
        .crc_byte       (crc_byte),
        .crc_byte_valid (crc_byte_valid)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  cmd;
        logic [15:0] addr;
        logic [7:0]  nbytes;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'hF0, 16'h0000, 8'd16, 8'h11},
        '{1'b0, 8'hAA, 16'h0005, 8'd11, 8'h3C},
        '{1'b1, 8'h0F, 16'h0010, 8'd3,  8'h81},
        '{1'b1, 8'h0F, 16'hFFFE, 8'd3,  8'hE7},
        '{1'b0, 8'hF0, 16'hFFFC, 8'd12, 8'h52}
    };

    function automatic logic [15:0] model_fold(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] tag, input logic [7:0] d);
        byte_valid = 1'b1;
        byte_tag   = tag;
        byte_data  = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic start(input logic wr);
        txn_start = 1'b1;
        txn_write = wr;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic expect_emit(input string req, input logic [15:0] model);
        logic [15:0] inv;
        inv = ~model;
        chk(req, "strobe", {31'd0, crc_ready}, 32'd1);
        chk(req, "low byte", {24'd0, crc_byte}, {24'd0, inv[7:0]});
        chk(req, "word", {16'd0, crc_out}, {16'd0, inv});
        @(negedge clk);
        chk(req, "strobe drop", {31'd0, crc_ready}, 32'd0);
        chk(req, "byte valid hi", {31'd0, crc_byte_valid}, 32'd1);
        chk(req, "high byte", {24'd0, crc_byte}, {24'd0, inv[15:8]});
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        vec_t        t;
        logic [15:0] m, a;
        logic [7:0]  d;
        logic        wrapped;
        int          pass;
        string       lbl;
        logic [15:0] inv;

        rst_n = 1'b0; txn_start = 1'b0; txn_write = 1'b0;
        byte_valid = 1'b0; byte_tag = 2'd0; byte_data = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state, and bytes before any start are ignored
        chk("R3", "ready after reset", {31'd0, crc_ready}, 32'd0);
        chk("R3", "byte valid after reset", {31'd0, crc_byte_valid}, 32'd0);
        chk("R2", "clear word inverted", {16'd0, crc_out}, 32'h0000FFFF);
        send(2'd0, 8'hF0); send(2'd1, 8'h07); send(2'd2, 8'h00); send(2'd3, 8'h5A);
        chk("R3", "no strobe before start", {31'd0, crc_ready | crc_byte_valid}, 32'd0);
        chk("R3", "register untouched before start", {16'd0, crc_out}, 32'h0000FFFF);

        // R1: known check value over bytes 0x31..0x39
        start(1'b0);
        send(2'd0, 8'h31); send(2'd1, 8'h32); send(2'd2, 8'h33);
        for (int i = 0; i < 6; i++) send(2'd3, 8'(8'h34 + i));
        chk("R1", "known strobe", {31'd0, crc_ready}, 32'd1);
        chk("R1", "known word", {16'd0, crc_out}, 32'h000044C2);
        chk("R1", "known low byte", {24'd0, crc_byte}, 32'h000000C2);
        @(negedge clk);
        chk("R1", "known high byte", {24'd0, crc_byte}, 32'h00000044);
        @(negedge clk);

        // Vector table walk: R5, R6, R7, R8, R11
        for (int v = 0; v < NV; v++) begin
            t = VECS[v];
            start(t.wr);
            m = 16'h0000;
            m = model_fold(m, t.cmd);          send(2'd0, t.cmd);
            m = model_fold(m, t.addr[7:0]);    send(2'd1, t.addr[7:0]);
            m = model_fold(m, t.addr[15:8]);   send(2'd2, t.addr[15:8]);
            a = t.addr;
            pass = 0;
            wrapped = 1'b0;
            for (int i = 0; i < int'(t.nbytes); i++) begin
                d = t.seed + 8'(i * 29);
                m = model_fold(m, d);
                send(2'd3, d);
                if (t.wr || a[2:0] == 3'd7) begin
                    lbl = (pass == 0) ? (t.wr ? "R7" : "R5") : (t.wr ? "R8" : "R6");
                    if (wrapped || a == 16'hFFFF) lbl = {lbl, "/R11"};
                    expect_emit(lbl, m);
                    pass++;
                    if (a == 16'hFFFF) wrapped = 1'b1;
                    a = a + 16'd1;
                    m = t.wr ? a : 16'h0000;
                end else begin
                    chk(t.wr ? "R7" : "R5", "no strobe mid-page", {31'd0, crc_ready}, 32'd0);
                    if (a == 16'hFFFF) wrapped = 1'b1;
                    a = a + 16'd1;
                end
            end
        end

        // R4: misplaced tags are ignored
        start(1'b1);
        send(2'd3, 8'h99);
        chk("R4", "data tag in command slot", {31'd0, crc_byte_valid}, 32'd0);
        send(2'd0, 8'h0F);
        send(2'd3, 8'h44);
        send(2'd1, 8'h34);
        send(2'd0, 8'h12);
        send(2'd2, 8'h12);
        send(2'd3, 8'h66);
        m = model_fold(model_fold(model_fold(model_fold(16'h0000, 8'h0F), 8'h34), 8'h12), 8'h66);
        expect_emit("R4", m);

        // R9: byte offered during emit is ignored
        start(1'b1);
        send(2'd0, 8'h0F); send(2'd1, 8'h20); send(2'd2, 8'h01);
        m = model_fold(model_fold(model_fold(model_fold(16'h0000, 8'h0F), 8'h20), 8'h01), 8'h5A);
        send(2'd3, 8'h5A);
        inv = ~m;
        chk("R9", "strobe", {31'd0, crc_ready}, 32'd1);
        chk("R9", "low byte", {24'd0, crc_byte}, {24'd0, inv[7:0]});
        byte_valid = 1'b1; byte_tag = 2'd3; byte_data = 8'hC3;
        @(negedge clk);
        byte_valid = 1'b0;
        chk("R9", "high byte with stray input", {24'd0, crc_byte}, {24'd0, inv[15:8]});
        @(negedge clk);
        m = model_fold(16'h0121, 8'h77);
        send(2'd3, 8'h77);
        expect_emit("R9", m);

        // R10: start wins over a byte, and aborts a read in progress
        start(1'b0);
        send(2'd0, 8'hF0); send(2'd1, 8'h03); send(2'd2, 8'h00); send(2'd3, 8'h11);
        txn_start = 1'b1; txn_write = 1'b1;
        byte_valid = 1'b1; byte_tag = 2'd3; byte_data = 8'hEE;
        @(negedge clk);
        txn_start = 1'b0; byte_valid = 1'b0;
        chk("R10", "quiet after restart", {31'd0, crc_byte_valid}, 32'd0);
        chk("R10", "register cleared", {16'd0, crc_out}, 32'h0000FFFF);
        send(2'd0, 8'h0F); send(2'd1, 8'h00); send(2'd2, 8'h02); send(2'd3, 8'h21);
        m = model_fold(model_fold(model_fold(model_fold(16'h0000, 8'h0F), 8'h00), 8'h02), 8'h21);
        expect_emit("R10", m);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule